// File: doc/BRIEF.md
# Tic-Tac-Toe Move Referee

This block keeps the state of a three-by-three noughts-and-crosses board and referees one move at a time. A requester raises a strobe together with the player's mark and the target row and column. The engine latches the request and checks whether the target cell can take a mark. It then either rejects the move as a repeat or writes the mark. After a write it judges the new position for a completed line and for a full board. Every request is answered by a one-cycle `done` pulse, and the result flags are valid only in that cycle.

A small controller with three states runs each request: idle/start, check and fill. After any answered request, including one that wins or fills the board, the controller goes back to idle. A registered mask of winning cells stays on the outputs so that a renderer can highlight the completed line or lines. A new-game pulse or the synchronous reset empties the board and drops every flag and the mask.

Top module: `board_referee`

## Requirements
- R1: While `rst` or `new_game` is high at a rising edge, the board, `win_cells` and every status flag are cleared to zero at that edge.
- R2: A request is taken only when `req` is sampled high at a rising edge after being sampled low at the previous edge, and only while the controller is idle. Holding `req` high produces exactly one answer.
- R3: A move to a free cell stores its mark in cell index `row*3+col`, which occupies bits `[2*i+1:2*i]` of `board`. The code is 01 for X (`req_o`=0) and 10 for O (`req_o`=1), and 00 means empty. `done` rises at the third rising edge counted from the edge that accepted the request, and the board changes at that same edge.
- R4: A move to a cell already holding a mark pulses `done` with `dup_hit` at the second rising edge counted from the accepting edge, and leaves the board unchanged.
- R5: A row or column value of 3 is answered like R4 (`dup_hit`, no write).
- R6: `done` lasts exactly one cycle. `dup_hit`, `board_full`, `x_won` and `o_won` are zero in every cycle where `done` is low.
- R7: With the `done` of a write, `x_won` (respectively `o_won`) is 1 when the board after the write has any row, column or diagonal holding three X (respectively O).
- R8: With the `done` of a write, `board_full` is 1 when none of the nine cells is empty after the write.
- R9: `win_cells` bit `i` is 1 exactly when cell `i` lies on a completed line of the current board. The mask updates at the same edge as `board` and holds until the board changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| new_game | input | 1 | Clears board and flags |
| req | input | 1 | Move request strobe, rising-edge sensitive |
| req_o | input | 1 | Mark of the move: 0 = X, 1 = O |
| req_row | input | 2 | Target row, 0..2 valid |
| req_col | input | 2 | Target column, 0..2 valid |
| done | output | 1 | One-cycle answer pulse |
| dup_hit | output | 1 | Move rejected (occupied or out of range) |
| board_full | output | 1 | No empty cell after the write |
| x_won | output | 1 | X holds a complete line |
| o_won | output | 1 | O holds a complete line |
| win_cells | output | 9 | Cells on completed lines, row-major |
| board | output | 18 | Two-bit cell codes, cell i at bits 2i+1:2i |

## Verification
The hardest conditions to reach from the ports are positions where a win and a full board arrive on the same move, and positions where lines from both marks coexist. Nothing forbids further moves after a win, so a run of random marks and coordinates keeps playing on a won board. Most new-game pulses are withheld until the board fills, which lets overlapping lines and late wins pile up. Directed sequences cover a row, a column and an anti-diagonal win, a drawn full board, a held strobe, and out-of-range coordinates.

// File: rtl/board_pkg.sv
package board_pkg;

  typedef enum logic [1:0] {
    CELL_EMPTY = 2'b00,
    CELL_X     = 2'b01,
    CELL_O     = 2'b10
  } cell_t;

  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_CHECK = 2'd1,
    ST_FILL  = 2'd2
  } ref_state_t;

  function automatic logic [1:0] mark_code(input logic is_o);
    return is_o ? CELL_O : CELL_X;
  endfunction

endpackage

// File: rtl/cell_bank.sv
module cell_bank #(
  parameter int CELLS = 9,
  parameter int IDX_W = $clog2(CELLS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [1:0]           wr_code,
  output logic [2*CELLS-1:0]   cells_q,
  output logic [2*CELLS-1:0]   cells_d
);

  // next board: clear wins over a write
  always_comb begin
    cells_d = cells_q;
    if (clear) begin
      cells_d = '0;
    end else if (wr_en) begin
      cells_d[2*wr_idx +: 2] = wr_code;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cells_q <= '0;
    end else begin
      cells_q <= cells_d;
    end
  end

  AST_WRITE_ONLY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !clear) |-> (cells_q[2*wr_idx +: 2] == 2'b00)); // R4

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cells_q == '0)); // R1

endmodule

// File: rtl/line_judge.sv
module line_judge #(
  parameter int SIDE  = 3,
  parameter int CELLS = SIDE * SIDE
) (
  input  logic [2*CELLS-1:0] cells,
  output logic               x_line,
  output logic               o_line,
  output logic               all_full,
  output logic [CELLS-1:0]   hit_mask
);
  import board_pkg::*;

  localparam int LINES = 2 * SIDE + 2;

  // lines 0..SIDE-1 rows, SIDE..2*SIDE-1 columns, then main and anti diagonal
  function automatic logic [CELLS-1:0] line_cells(input int l);
    logic [CELLS-1:0] m;
    m = '0;
    for (int k = 0; k < SIDE; k++) begin
      if (l < SIDE)            m[l*SIDE + k] = 1'b1;
      else if (l < 2*SIDE)     m[k*SIDE + (l - SIDE)] = 1'b1;
      else if (l == 2*SIDE)    m[k*SIDE + k] = 1'b1;
      else                     m[k*SIDE + (SIDE - 1 - k)] = 1'b1;
    end
    return m;
  endfunction

  logic [LINES-1:0] x_hit;
  logic [LINES-1:0] o_hit;
  logic [CELLS-1:0] line_sel [LINES];

  for (genvar gl = 0; gl < LINES; gl++) begin : g_line
    localparam logic [CELLS-1:0] MASK = line_cells(gl);
    logic all_x, all_o;
    always_comb begin
      all_x = 1'b1;
      all_o = 1'b1;
      for (int c = 0; c < CELLS; c++) begin
        if (MASK[c]) begin
          if (cells[2*c +: 2] != CELL_X) all_x = 1'b0;
          if (cells[2*c +: 2] != CELL_O) all_o = 1'b0;
        end
      end
    end
    assign x_hit[gl]    = all_x;
    assign o_hit[gl]    = all_o;
    assign line_sel[gl] = MASK;
  end

  always_comb begin
    hit_mask = '0;
    for (int l = 0; l < LINES; l++) begin
      if (x_hit[l] || o_hit[l]) hit_mask = hit_mask | line_sel[l];
    end
  end

  always_comb begin
    all_full = 1'b1;
    for (int c = 0; c < CELLS; c++) begin
      if (cells[2*c +: 2] == CELL_EMPTY) all_full = 1'b0;
    end
  end

  assign x_line = |x_hit;
  assign o_line = |o_hit;

endmodule

// File: rtl/move_ctrl.sv
module move_ctrl #(
  parameter int SIDE  = 3,
  parameter int CELLS = SIDE * SIDE,
  parameter int RC_W  = $clog2(SIDE),
  parameter int IDX_W = $clog2(CELLS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                new_game,
  input  logic                req,
  input  logic                req_o,
  input  logic [RC_W-1:0]     req_row,
  input  logic [RC_W-1:0]     req_col,
  input  logic [2*CELLS-1:0]  cells_q,
  input  logic                x_line,
  input  logic                o_line,
  input  logic                full_next,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [1:0]          wr_code,
  output logic                done,
  output logic                dup_hit,
  output logic                board_full,
  output logic                x_won,
  output logic                o_won
);
  import board_pkg::*;

  ref_state_t      state;
  logic            req_q;
  logic            mark_q;
  logic [RC_W-1:0] row_q;
  logic [RC_W-1:0] col_q;
  logic            in_range;
  logic [IDX_W-1:0] idx;
  logic            taken;

  assign in_range = (int'(row_q) < SIDE) && (int'(col_q) < SIDE);
  assign idx      = in_range ? IDX_W'(int'(row_q) * SIDE + int'(col_q)) : '0;
  assign taken    = !in_range || (cells_q[2*idx +: 2] != CELL_EMPTY);

  assign wr_en   = (state == ST_FILL);
  assign wr_idx  = idx;
  assign wr_code = mark_code(mark_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_START;
      req_q      <= 1'b0;
      mark_q     <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      done       <= 1'b0;
      dup_hit    <= 1'b0;
      board_full <= 1'b0;
      x_won      <= 1'b0;
      o_won      <= 1'b0;
    end else begin
      req_q      <= req;
      done       <= 1'b0;
      dup_hit    <= 1'b0;
      board_full <= 1'b0;
      x_won      <= 1'b0;
      o_won      <= 1'b0;
      if (new_game) begin
        state <= ST_START;
      end else begin
        case (state)
          ST_START: begin
            if (req && !req_q) begin
              mark_q <= req_o;
              row_q  <= req_row;
              col_q  <= req_col;
              state  <= ST_CHECK;
            end
          end
          ST_CHECK: begin
            if (taken) begin
              done    <= 1'b1;
              dup_hit <= 1'b1;
              state   <= ST_START;
            end else begin
              state <= ST_FILL;
            end
          end
          ST_FILL: begin
            done       <= 1'b1;
            board_full <= full_next;
            x_won      <= x_line;
            o_won      <= o_line;
            state      <= ST_START;
          end
          default: state <= ST_START;
        endcase
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_FLAGS_NEED_DONE: assert property (@(posedge clk) disable iff (rst)
    (dup_hit || board_full || x_won || o_won) |-> done); // R6

  AST_FILL_AFTER_CHECK: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FILL) |-> ($past(state) == ST_CHECK)); // R3

endmodule

// File: rtl/board_referee.sv
module board_referee #(
  parameter int SIDE  = 3,
  parameter int CELLS = SIDE * SIDE,
  parameter int RC_W  = $clog2(SIDE),
  parameter int IDX_W = $clog2(CELLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               new_game,
  input  logic               req,
  input  logic               req_o,
  input  logic [RC_W-1:0]    req_row,
  input  logic [RC_W-1:0]    req_col,
  output logic               done,
  output logic               dup_hit,
  output logic               board_full,
  output logic               x_won,
  output logic               o_won,
  output logic [CELLS-1:0]   win_cells,
  output logic [2*CELLS-1:0] board
);

  logic [2*CELLS-1:0] cells_q;
  logic [2*CELLS-1:0] cells_d;
  logic               wr_en;
  logic [IDX_W-1:0]   wr_idx;
  logic [1:0]         wr_code;
  logic               x_line, o_line, full_next;
  logic [CELLS-1:0]   hit_mask;

  cell_bank #(.CELLS(CELLS), .IDX_W(IDX_W)) i_cell_bank (
    .clk     (clk),
    .rst     (rst),
    .clear   (new_game),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_code (wr_code),
    .cells_q (cells_q),
    .cells_d (cells_d)
  );

  line_judge #(.SIDE(SIDE), .CELLS(CELLS)) i_line_judge (
    .cells    (cells_d),
    .x_line   (x_line),
    .o_line   (o_line),
    .all_full (full_next),
    .hit_mask (hit_mask)
  );

  move_ctrl #(.SIDE(SIDE), .CELLS(CELLS), .RC_W(RC_W), .IDX_W(IDX_W)) i_move_ctrl (
    .clk        (clk),
    .rst        (rst),
    .new_game   (new_game),
    .req        (req),
    .req_o      (req_o),
    .req_row    (req_row),
    .req_col    (req_col),
    .cells_q    (cells_q),
    .x_line     (x_line),
    .o_line     (o_line),
    .full_next  (full_next),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_code    (wr_code),
    .done       (done),
    .dup_hit    (dup_hit),
    .board_full (board_full),
    .x_won      (x_won),
    .o_won      (o_won)
  );

  // mask judged on the next board so it lands with the board update
  always_ff @(posedge clk) begin
    if (rst) begin
      win_cells <= '0;
    end else begin
      win_cells <= hit_mask;
    end
  end

  assign board = cells_q;

  AST_REPEAT_KEEPS_BOARD: assert property (@(posedge clk) disable iff (rst)
    dup_hit |-> $stable(board)); // R4

  AST_WIN_HAS_MASK: assert property (@(posedge clk) disable iff (rst)
    (x_won || o_won) |-> (win_cells != '0)); // R9

  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (rst)
    new_game |=> (win_cells == '0)); // R1

endmodule

// File: tb/test_board_referee.sv
module test_board_referee;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       new_game = 1'b0;
  logic       req = 1'b0;
  logic       req_o = 1'b0;
  logic [1:0] req_row = '0;
  logic [1:0] req_col = '0;
  logic       done, dup_hit, board_full, x_won, o_won;
  logic [8:0] win_cells;
  logic [17:0] board;

  int checks = 0;
  int errors = 0;
  int mdl [9];

  always #(CLK_PERIOD/2) clk = ~clk;

  board_referee i_board_referee (
    .clk(clk), .rst(rst), .new_game(new_game), .req(req), .req_o(req_o),
    .req_row(req_row), .req_col(req_col), .done(done), .dup_hit(dup_hit),
    .board_full(board_full), .x_won(x_won), .o_won(o_won),
    .win_cells(win_cells), .board(board)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit line_of(input int m);
    bit r = 0;
    for (int i = 0; i < 3; i++) begin
      if (mdl[i*3] == m && mdl[i*3+1] == m && mdl[i*3+2] == m) r = 1;
      if (mdl[i] == m && mdl[i+3] == m && mdl[i+6] == m) r = 1;
    end
    if (mdl[0] == m && mdl[4] == m && mdl[8] == m) r = 1;
    if (mdl[2] == m && mdl[4] == m && mdl[6] == m) r = 1;
    return r;
  endfunction

  function automatic logic [8:0] mask_of();
    logic [8:0] k = '0;
    for (int i = 0; i < 3; i++) begin
      if (mdl[i*3] != 0 && mdl[i*3] == mdl[i*3+1] && mdl[i*3] == mdl[i*3+2])
        k = k | (9'b111 << (i*3));
      if (mdl[i] != 0 && mdl[i] == mdl[i+3] && mdl[i] == mdl[i+6])
        k = k | (9'b001001001 << i);
    end
    if (mdl[0] != 0 && mdl[0] == mdl[4] && mdl[0] == mdl[8]) k = k | 9'b100010001;
    if (mdl[2] != 0 && mdl[2] == mdl[4] && mdl[2] == mdl[6]) k = k | 9'b001010100;
    return k;
  endfunction

  function automatic bit full_of();
    bit f = 1;
    for (int i = 0; i < 9; i++) if (mdl[i] == 0) f = 0;
    return f;
  endfunction

  function automatic logic [17:0] pack_of();
    logic [17:0] b = '0;
    for (int i = 0; i < 9; i++) b[2*i +: 2] = 2'(mdl[i]);
    return b;
  endfunction

  task automatic fresh_game();
    @(negedge clk);
    new_game = 1'b1;
    @(negedge clk);
    new_game = 1'b0;
    for (int i = 0; i < 9; i++) mdl[i] = 0;
    chk("R1 board cleared", 32'(board), 32'(0));
    chk("R1 mask cleared", 32'(win_cells), 32'(0));
  endtask

  task automatic move(input bit o, input int r, input int c);
    bit rep;
    int lat;
    string rt;
    rt  = (r > 2 || c > 2) ? "R5" : "R4";
    rep = (r > 2 || c > 2) ? 1'b1 : (mdl[r*3+c] != 0);
    lat = rep ? 2 : 3;
    @(negedge clk);
    req_o = o; req_row = 2'(r); req_col = 2'(c); req = 1'b1;
    for (int k = 1; k < lat; k++) begin
      @(negedge clk);
      chk("R3 no early done", 32'(done), 32'(0));
    end
    @(negedge clk);
    if (!rep) mdl[r*3+c] = o ? 2 : 1;
    chk("R6 done pulse", 32'(done), 32'(1));
    chk(rep ? rt : "R3 dup low", 32'(dup_hit), 32'(rep));
    chk("R3 board", 32'(board), 32'(pack_of()));
    chk("R8 full", 32'(board_full), 32'(rep ? 1'b0 : full_of()));
    chk("R7 x_won", 32'(x_won), 32'(rep ? 1'b0 : line_of(1)));
    chk("R7 o_won", 32'(o_won), 32'(rep ? 1'b0 : line_of(2)));
    req = 1'b0;
    @(negedge clk);
    chk("R6 done drops", 32'(done), 32'(0));
    chk("R6 flags drop", 32'({dup_hit, board_full, x_won, o_won}), 32'(0));
    chk("R9 mask", 32'(win_cells), 32'(mask_of()));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL R6 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ndone;
    for (int i = 0; i < 9; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset board", 32'(board), 32'(0));
    chk("R1 reset flags", 32'({done, dup_hit, board_full, x_won, o_won}), 32'(0));
    chk("R1 reset mask", 32'(win_cells), 32'(0));
    rst = 1'b0;

    // row win for X
    move(0, 0, 0); move(1, 1, 1); move(0, 0, 1); move(1, 2, 2); move(0, 0, 2);
    chk("R9 top row mask", 32'(win_cells), 32'h007);
    move(1, 0, 0);               // R4 occupied
    move(0, 3, 1);               // R5 row out of range
    move(1, 1, 3);               // R5 column out of range
    fresh_game();

    // column win for O, then anti-diagonal
    move(1, 0, 1); move(0, 0, 0); move(1, 1, 1); move(0, 2, 2); move(1, 2, 1);
    chk("R9 middle column", 32'(win_cells), 32'h092);
    fresh_game();
    move(1, 0, 2); move(1, 1, 1); move(1, 2, 0);
    chk("R9 anti diagonal", 32'(win_cells), 32'h054);
    fresh_game();

    // drawn full board: X O X / X O O / O X X
    move(0, 0, 0); move(1, 0, 1); move(0, 0, 2); move(0, 1, 0); move(1, 1, 1);
    move(1, 1, 2); move(1, 2, 0); move(0, 2, 1); move(0, 2, 2);
    chk("R8 draw has no mask", 32'(win_cells), 32'(0));
    fresh_game();

    // held strobe gives one answer (R2)
    @(negedge clk);
    req_o = 1'b0; req_row = 2'd1; req_col = 2'd2; req = 1'b1;
    ndone = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (done) ndone++;
    end
    req = 1'b0;
    mdl[5] = 1;
    chk("R2 single answer", 32'(ndone), 32'(1));
    chk("R2 one cell written", 32'(board), 32'(pack_of()));
    fresh_game();

    // random play with a fixed seed
    void'($urandom(32'd4711));
    for (int n = 0; n < 500; n++) begin
      if (full_of() || ($urandom % 40) == 0) fresh_game();
      move(1'($urandom % 2), int'($urandom % 4), int'($urandom % 4));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule